// File: doc/BRIEF.md
# Grouped Four-Bit Pattern Recognizer

This block watches a serial bit stream, one bit per clock, and cuts it into back-to-back frames of four bits. The frames do not overlap. The first bit sampled after reset leaves its active level opens the first frame. When a frame's last bit arrives, the block judges the whole frame. If the frame is one of the two accepted words, it raises a single flag pulse. Frames are compared with their earliest bit as the most significant position. The accepted words are 1010 and 0110.

The block is a reduced state machine with seven states. A full decision tree over four bits would need fifteen states. In the reduced machine, a state tracks only whether the frame can still match, and all frames that can no longer match share one path. The flag is registered. It appears in the clock cycle that follows the edge which sampled the fourth bit. After every fourth bit the machine goes back to its frame-start state, whatever the verdict was. The reset is synchronous and active low, and it can also be used to resynchronise the framing in the middle of a stream. A parameter selects between binary and one-hot storage of the state.

Top module: `grp4_recognizer`

## Requirements
- R1: A clock edge that samples `rst_n` low puts the machine in its frame-start state. `z_out` is then 0 in the following cycle.
- R2: The first bit sampled with `rst_n` high opens a frame. Each following run of four sampled bits forms the next frame, so frames are consecutive and never overlap.
- R3: A frame whose bits, earliest first, are 1, 0, 1, 0 (value 4'b1010 with the earliest bit as bit 3) drives `z_out` to 1. This happens in the cycle after the edge that sampled its fourth bit.
- R4: A frame whose bits, earliest first, are 0, 1, 1, 0 (value 4'b0110) drives `z_out` to 1 in that same cycle. Any of the other fourteen frame values leaves `z_out` at 0 there.
- R5: In the cycles that follow the sampling of a frame's first, second or third bit, `z_out` is 0.
- R6: `z_out` is high for exactly one clock cycle per matching frame.
- R7: After a frame's fourth bit the machine is back in its frame-start state. Because of this, an accepted word that straddles a frame boundary is not reported.
- R8: Reset wins over frame completion and discards a partial frame. If `rst_n` is low on the edge that samples a fourth bit, no pulse follows. In either case the next bit sampled with `rst_n` high opens a fresh frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one stream bit is sampled per rising edge |
| rst_n | input | 1 | Synchronous active-low reset to the frame-start state |
| x_in | input | 1 | Serial stream bit |
| z_out | output | 1 | Registered match flag, one cycle per accepted frame |

## Verification
Two events can land on the same edge: frame completion (with its possible match pulse) and a synchronous reset. The bench provokes this by driving the first three bits of an accepted word and then holding `rst_n` low on the edge that samples the fourth bit. It judges the outcome in two steps. First, `z_out` must stay 0 in the next cycle. Second, an accepted word sent immediately afterwards must be recognised, which shows that the framing restarted at that bit. A reset in the middle of a frame, and words that straddle a frame boundary, are checked the same way.

// File: rtl/grp4_pkg.sv
// Shared definitions for the grouped four-bit recognizer.
// Assumes frames are four bits and both accepted words end in the same two bits.
package grp4_pkg;

    localparam int GRP4_FRAME_LEN = 4;
    localparam int GRP4_PHASE_W   = $clog2(GRP4_FRAME_LEN);
    localparam logic [GRP4_FRAME_LEN-1:0] GRP4_WORD_A = 4'b1010;
    localparam logic [GRP4_FRAME_LEN-1:0] GRP4_WORD_B = 4'b0110;

    localparam int GRP4_NUM_STATES = 7;
    localparam int GRP4_STATE_W    = $clog2(GRP4_NUM_STATES);

    // Reduced state set: prefix-tracking states plus a shared miss path.
    typedef enum logic [GRP4_STATE_W-1:0] {
        ST_START = 3'd0,   // waiting for first bit of a frame
        ST_LEAD_A = 3'd1,  // first bit agrees with word A
        ST_LEAD_B = 3'd2,  // first bit agrees with word B
        ST_PFX2  = 3'd3,   // two bits still consistent with a word
        ST_MISS2 = 3'd4,   // two bits, no word possible
        ST_PFX3  = 3'd5,   // three bits still consistent
        ST_MISS3 = 3'd6    // three bits, no word possible
    } grp4_state_e;

endpackage

// File: rtl/grp4_next_state.sv
// Next-state and match logic of the recognizer.
// Purely combinational; assumes the state input is one of the seven legal codes.
module grp4_next_state
    import grp4_pkg::*;
(
    input  grp4_state_e state_i,
    input  logic        bit_i,
    output grp4_state_e state_o,
    output logic        hit_o
);

    // Transition table: advance along the surviving prefix or the miss path.
    always_comb begin
        state_o = ST_START;
        hit_o   = 1'b0;
        unique case (state_i)
            ST_START: begin
                state_o = (bit_i == GRP4_WORD_A[3]) ? ST_LEAD_A : ST_LEAD_B;
            end
            ST_LEAD_A: begin
                state_o = (bit_i == GRP4_WORD_A[2]) ? ST_PFX2 : ST_MISS2;
            end
            ST_LEAD_B: begin
                state_o = (bit_i == GRP4_WORD_B[2]) ? ST_PFX2 : ST_MISS2;
            end
            ST_PFX2: begin
                state_o = (bit_i == GRP4_WORD_A[1]) ? ST_PFX3 : ST_MISS3;
            end
            ST_MISS2: begin
                state_o = ST_MISS3;
            end
            ST_PFX3: begin
                state_o = ST_START;
                hit_o   = (bit_i == GRP4_WORD_A[0]);
            end
            ST_MISS3: begin
                state_o = ST_START;
            end
            default: begin
                state_o = ST_START;
            end
        endcase
    end

endmodule

// File: rtl/grp4_state_reg.sv
// State storage for the recognizer, binary or one-hot by parameter.
// Assumes a synchronous active-low reset; the output is always a decoded enum.
module grp4_state_reg
    import grp4_pkg::*;
#(
    parameter bit ONE_HOT = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  grp4_state_e state_d,
    output grp4_state_e state_q
);

    generate
        if (ONE_HOT) begin : g_onehot
            logic [GRP4_NUM_STATES-1:0] hot_q;
            logic [GRP4_NUM_STATES-1:0] hot_d;

            // Encode the requested state as a single set bit.
            always_comb begin
                hot_d = '0;
                hot_d[state_d] = 1'b1;
            end

            // Hold the one-hot vector; reset sets the start bit.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hot_q <= '0;
                    hot_q[ST_START] <= 1'b1;
                end else begin
                    hot_q <= hot_d;
                end
            end

            // Decode the set bit back to a state code.
            always_comb begin
                state_q = ST_START;
                for (int i = 0; i < GRP4_NUM_STATES; i++) begin
                    if (hot_q[i]) begin
                        state_q = grp4_state_e'(i[GRP4_STATE_W-1:0]);
                    end
                end
            end
        end else begin : g_binary
            grp4_state_e bin_q;

            // Hold the binary state code.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    bin_q <= ST_START;
                end else begin
                    bin_q <= state_d;
                end
            end

            assign state_q = bin_q;
        end
    endgenerate

endmodule

// File: rtl/grp4_flag_reg.sv
// Registers the match strobe so the flag comes straight from a flop.
// Assumes a synchronous active-low reset.
module grp4_flag_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    output logic flag_o
);

    // Capture the strobe computed on the edge sampling the fourth bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else begin
            flag_o <= hit_i;
        end
    end

endmodule

// File: rtl/grp4_recognizer.sv
// Grouped four-bit recognizer: splits a serial stream into frames of four
// and pulses z_out one cycle after a frame equal to an accepted word.
// Assumes one valid bit per clock and synchronous active-low reset.
module grp4_recognizer
    import grp4_pkg::*;
#(
    parameter bit ONE_HOT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic x_in,
    output logic z_out
);

    grp4_state_e state_q;
    grp4_state_e state_d;
    logic        hit;

    grp4_next_state u_next (
        .state_i (state_q),
        .bit_i   (x_in),
        .state_o (state_d),
        .hit_o   (hit)
    );

    grp4_state_reg #(
        .ONE_HOT (ONE_HOT)
    ) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_d (state_d),
        .state_q (state_q)
    );

    grp4_flag_reg u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit_i  (hit),
        .flag_o (z_out)
    );

endmodule

// File: rtl/grp4_recognizer_chk.sv
// Property checker for grp4_recognizer; keeps its own frame phase and bit
// history and relates them to the flag and the state. Bound below.
module grp4_recognizer_chk
    import grp4_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        x_in,
    input logic        z_out,
    input grp4_state_e state_q
);

    logic [GRP4_PHASE_W-1:0]   phase_q;
    logic [GRP4_FRAME_LEN-2:0] hist_q;

    // Independent frame position counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // Recent bits of the stream.
    always_ff @(posedge clk) begin
        hist_q <= {hist_q[GRP4_FRAME_LEN-3:0], x_in};
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (state_q == ST_START) && !z_out);

    // R5
    early_bits_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        z_out |-> (phase_q == '0));

    // R3 R4
    frame_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == 2'd3) |=> (z_out == $past(({hist_q, x_in} == GRP4_WORD_A) ||
                                              ({hist_q, x_in} == GRP4_WORD_B))));

    // R6
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        z_out |=> !z_out);

    // R7
    frame_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == 2'd3) |=> (state_q == ST_START));

endmodule

bind grp4_recognizer grp4_recognizer_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .x_in    (x_in),
    .z_out   (z_out),
    .state_q (state_q)
);

// File: tb/grp4_recognizer_tb_top.sv
// Bench: behavioural frame model (a queue of bits) compared every clock.
module grp4_recognizer_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic x_in  = 1'b0;
    logic z_out;

    always #2.5 clk = ~clk;

    grp4_recognizer dut_i (
        .clk   (clk),
        .rst_n (rst_n),
        .x_in  (x_in),
        .z_out (z_out)
    );

    int    checks   = 0;
    int    fails    = 0;
    bit    exp_z    = 1'b0;
    string exp_tag  = "R1";
    bit    frame[$];
    bit    finished = 1'b0;

    // One clock: check the previous edge's result, drive the next bit, update model.
    task automatic step(input bit b, input bit rn, input string tag);
        logic [3:0] w;
        @(negedge clk);
        checks++;
        if (z_out !== exp_z) begin
            fails++;
            $display("FAIL %s: z_out=%0b expected %0b at %0t", exp_tag, z_out, exp_z, $time);
        end
        x_in  = b;
        rst_n = rn;
        if (!rn) begin
            frame.delete();
            exp_z   = 1'b0;
            exp_tag = tag;
        end else begin
            frame.push_back(b);
            if (frame.size() == 4) begin
                w = {frame[0], frame[1], frame[2], frame[3]};
                exp_z = (w == 4'b1010) || (w == 4'b0110);
                exp_tag = (w == 4'b1010) ? "R3" : (w == 4'b0110) ? "R4" : tag;
                frame.delete();
            end else begin
                exp_tag = exp_z ? "R6" : "R5";
                exp_z   = 1'b0;
            end
        end
    endtask

    task automatic send_frame(input logic [3:0] v, input string tag);
        for (int i = 3; i >= 0; i--) step(v[i], 1'b1, tag);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        // R1: reset state
        repeat (3) step(1'b0, 1'b0, "R1");
        // R2: the worked stream
        send_frame(4'b0010, "R2");
        send_frame(4'b0110, "R2");
        send_frame(4'b1100, "R2");
        send_frame(4'b1010, "R2");
        send_frame(4'b0011, "R2");
        // R4: every frame value
        for (int v = 0; v < 16; v++) send_frame(v[3:0], "R4");
        // R7: accepted words straddling frame boundaries
        send_frame(4'b0101, "R7");
        send_frame(4'b0011, "R7");
        send_frame(4'b0000, "R7");
        // R8: reset in mid-frame discards partial bits
        step(1'b1, 1'b1, "R8");
        step(1'b0, 1'b1, "R8");
        step(1'b1, 1'b0, "R8");
        send_frame(4'b1010, "R8");
        // R8: reset on the fourth bit of an accepted word
        step(1'b1, 1'b1, "R8");
        step(1'b0, 1'b1, "R8");
        step(1'b1, 1'b1, "R8");
        step(1'b0, 1'b0, "R8");
        send_frame(4'b0110, "R8");
        // R2: random stream
        for (int i = 0; i < 1200; i++) step(1'($urandom_range(0, 1)), 1'b1, "R2");
        step(1'b0, 1'b1, "R2");
        finished = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 5);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule